// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms a 32-bit memory address from up to three terms. The terms are a base register, an index register shifted left by a small scale amount, and a displacement. Each term can be switched off independently, and a term that is switched off adds zero. The caller supplies an addressing descriptor that has already been decoded. The block sends the two register numbers out to a register file that has eight entries and reads back their contents in the same cycle.

The displacement field can be absent, 8 bits, 16 bits or 32 bits wide. A narrow displacement is sign-extended before it is added, and the sum wraps modulo 2^32. A valid descriptor produces a registered address, together with a valid flag, on the following clock edge. A descriptor with only a displacement gives an absolute address. A descriptor with only a base gives the contents of that register.

Top module: `scaled_addr_gen`

## Requirements
- R1: While `rstN` is low, `outValid` reads 0 and `outAddr` reads 0. Reset is asynchronous and active low.
- R2: `outValid` is 1 in the cycle after an edge that sampled `inValid` high, and 0 after an edge that sampled it low. Back-to-back valid descriptors each produce their own address.
- R3: An edge that samples `inValid` low leaves `outAddr` unchanged, whatever the other inputs are.
- R4: `rdIdxBase` equals `baseSel` and `rdIdxIndex` equals `indexSel` in the same cycle, with no register in the path.
- R5: With `baseEn` at 0, the base term is zero and `baseSel` has no effect on `outAddr`. With `baseEn` at 1, the base term is `rdDataBase`.
- R6: `scaleCode` sets the index multiplier: 0 gives ×1, 1 gives ×2, 2 gives ×4, and 3 also gives ×4. The multiplier is applied as a left shift.
- R7: With `indexEn` at 0, the index term is zero and `indexSel` and `scaleCode` have no effect on `outAddr`.
- R8: `dispSize` selects the displacement: 0 means none (zero), 1 means `dispRaw[7:0]` sign-extended, 2 means `dispRaw[15:0]` sign-extended, and 3 means all of `dispRaw`.
- R9: For sizes 1 and 2, the bits of `dispRaw` above the selected width have no effect on `outAddr`.
- R10: The sum, and the shifted index, wrap modulo 2^32. No overflow is reported.
- R11: A descriptor with only a 32-bit displacement yields `dispRaw` as the address. A descriptor with only a base yields that register's contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Descriptor valid |
| baseEn | input | 1 | Base term present |
| baseSel | input | 3 | Base register number |
| indexEn | input | 1 | Index term present |
| indexSel | input | 3 | Index register number |
| scaleCode | input | 2 | Index scale code |
| dispSize | input | 2 | Displacement size code |
| dispRaw | input | 32 | Raw displacement field |
| rdIdxBase | output | 3 | Register file read index for the base |
| rdIdxIndex | output | 3 | Register file read index for the index |
| rdDataBase | input | 32 | Register file data for the base |
| rdDataIndex | input | 32 | Register file data for the index |
| outValid | output | 1 | Address valid |
| outAddr | output | 32 | Registered effective address |

## Verification
Two functions can act in the same cycle: sign extension of a negative narrow displacement, and wraparound of the three-term sum past 2^32. The stimulus table sets up this case with descriptors such as an index of 12 plus an 8-bit displacement of 0x80, and a register holding 0xFFFFFFF0 plus a 16-bit displacement of 0x0010. The expected addresses were worked out by hand as 0xFFFFFF8C and 0. The table is driven as back-to-back valid descriptors, so each output is also checked for not carrying over from its neighbour.

// File: rtl/eag_pkg.sv
package eag_pkg;

  // displacement size codes carried on the dispSize pin
  typedef enum logic [1:0] {
    DISP_NONE = 2'd0,
    DISP_B8   = 2'd1,
    DISP_B16  = 2'd2,
    DISP_B32  = 2'd3
  } dispSizeT;

  // strobes passed from control to datapath
  typedef struct packed {
    logic loadAddr;
    logic markValid;
  } ctrlStrobeT;

endpackage

// File: rtl/eag_index_scale.sv
module eag_index_scale #(
  parameter int ADDR_W    = 32,
  parameter int CODE_W    = 2,
  parameter int MAX_SHIFT = 2
) (
  input  logic [ADDR_W-1:0] indexVal,
  input  logic [CODE_W-1:0] scaleCode,
  output logic [ADDR_W-1:0] scaled
);

  localparam int CAND_N = MAX_SHIFT + 1;

  logic [ADDR_W-1:0] cand [CAND_N];

  // one shifted copy per legal scale; codes beyond MAX_SHIFT saturate
  for (genvar s = 0; s < CAND_N; s++) begin : g_cand
    assign cand[s] = indexVal << s;
  end

  always_comb begin
    scaled = cand[0];
    for (int s = 1; s < CAND_N; s++) begin
      if (32'(scaleCode) >= s) scaled = cand[s];
    end
  end

endmodule

// File: rtl/eag_disp_ext.sv
module eag_disp_ext #(
  parameter int ADDR_W = 32
) (
  input  logic [1:0]        dispSize,
  input  logic [ADDR_W-1:0] dispRaw,
  output logic [ADDR_W-1:0] dispExt
);
  import eag_pkg::*;

  localparam int NARROW_W = 8;
  localparam int MID_W    = 16;

  dispSizeT sizeCode;

  always_comb begin
    sizeCode = dispSizeT'(dispSize);
    unique case (sizeCode)
      DISP_NONE: dispExt = '0;
      DISP_B8:   dispExt = {{(ADDR_W-NARROW_W){dispRaw[NARROW_W-1]}}, dispRaw[NARROW_W-1:0]};
      DISP_B16:  dispExt = {{(ADDR_W-MID_W){dispRaw[MID_W-1]}}, dispRaw[MID_W-1:0]};
      default:   dispExt = dispRaw;
    endcase
  end

endmodule

// File: rtl/eag_datapath.sv
module eag_datapath #(
  parameter int ADDR_W    = 32,
  parameter int CODE_W    = 2,
  parameter int MAX_SHIFT = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  eag_pkg::ctrlStrobeT strobe,
  input  logic                baseEn,
  input  logic                indexEn,
  input  logic [CODE_W-1:0]   scaleCode,
  input  logic [1:0]          dispSize,
  input  logic [ADDR_W-1:0]   dispRaw,
  input  logic [ADDR_W-1:0]   baseVal,
  input  logic [ADDR_W-1:0]   indexVal,
  output logic [ADDR_W-1:0]   outAddr
);

  logic [ADDR_W-1:0] scaledIdx;
  logic [ADDR_W-1:0] dispExt;
  logic [ADDR_W-1:0] baseTerm;
  logic [ADDR_W-1:0] indexTerm;
  logic [ADDR_W-1:0] addrSum;

  eag_index_scale #(
    .ADDR_W   (ADDR_W),
    .CODE_W   (CODE_W),
    .MAX_SHIFT(MAX_SHIFT)
  ) u_scale (
    .indexVal (indexVal),
    .scaleCode(scaleCode),
    .scaled   (scaledIdx)
  );

  eag_disp_ext #(
    .ADDR_W(ADDR_W)
  ) u_disp (
    .dispSize(dispSize),
    .dispRaw (dispRaw),
    .dispExt (dispExt)
  );

  // absent terms are forced to zero before the adder
  always_comb begin
    baseTerm  = baseEn  ? baseVal   : '0;
    indexTerm = indexEn ? scaledIdx : '0;
    addrSum   = baseTerm + indexTerm + dispExt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outAddr <= '0;
    end else if (strobe.loadAddr) begin
      outAddr <= addrSum;
    end
  end

endmodule

// File: rtl/eag_ctrl.sv
module eag_ctrl (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  output eag_pkg::ctrlStrobeT strobe,
  output logic                outValid
);

  always_comb begin
    strobe.loadAddr  = inValid;
    strobe.markValid = inValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
    end else begin
      outValid <= strobe.markValid;
    end
  end

endmodule

// File: rtl/scaled_addr_gen.sv
module scaled_addr_gen #(
  parameter int ADDR_W    = 32,
  parameter int REG_CNT   = 8,
  parameter int MAX_SHIFT = 2,
  parameter int CODE_W    = 2,
  localparam int SEL_W    = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              baseEn,
  input  logic [SEL_W-1:0]  baseSel,
  input  logic              indexEn,
  input  logic [SEL_W-1:0]  indexSel,
  input  logic [CODE_W-1:0] scaleCode,
  input  logic [1:0]        dispSize,
  input  logic [ADDR_W-1:0] dispRaw,
  output logic [SEL_W-1:0]  rdIdxBase,
  output logic [SEL_W-1:0]  rdIdxIndex,
  input  logic [ADDR_W-1:0] rdDataBase,
  input  logic [ADDR_W-1:0] rdDataIndex,
  output logic              outValid,
  output logic [ADDR_W-1:0] outAddr
);

  eag_pkg::ctrlStrobeT strobe;

  assign rdIdxBase  = baseSel;
  assign rdIdxIndex = indexSel;

  eag_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  eag_datapath #(
    .ADDR_W   (ADDR_W),
    .CODE_W   (CODE_W),
    .MAX_SHIFT(MAX_SHIFT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .baseEn   (baseEn),
    .indexEn  (indexEn),
    .scaleCode(scaleCode),
    .dispSize (dispSize),
    .dispRaw  (dispRaw),
    .baseVal  (rdDataBase),
    .indexVal (rdDataIndex),
    .outAddr  (outAddr)
  );

endmodule

// File: rtl/eag_checker.sv
module eag_checker #(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              baseEn,
  input logic [SEL_W-1:0]  baseSel,
  input logic              indexEn,
  input logic [SEL_W-1:0]  indexSel,
  input logic [1:0]        dispSize,
  input logic [ADDR_W-1:0] dispRaw,
  input logic [SEL_W-1:0]  rdIdxBase,
  input logic [SEL_W-1:0]  rdIdxIndex,
  input logic              outValid,
  input logic [ADDR_W-1:0] outAddr
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rstN) |-> (!outValid && outAddr == '0));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  assert_addr_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outAddr));

  assert_read_index_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdIdxBase == baseSel && rdIdxIndex == indexSel);

  assert_empty_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !baseEn && !indexEn && dispSize == 2'd0) |=> outAddr == '0);

  assert_absolute_R11: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !baseEn && !indexEn && dispSize == 2'd3) |=> outAddr == $past(dispRaw));

endmodule

bind scaled_addr_gen eag_checker #(
  .ADDR_W(ADDR_W),
  .SEL_W (SEL_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .baseEn    (baseEn),
  .baseSel   (baseSel),
  .indexEn   (indexEn),
  .indexSel  (indexSel),
  .dispSize  (dispSize),
  .dispRaw   (dispRaw),
  .rdIdxBase (rdIdxBase),
  .rdIdxIndex(rdIdxIndex),
  .outValid  (outValid),
  .outAddr   (outAddr)
);

// File: tb/scaled_addr_gen_bench.sv
module scaled_addr_gen_bench;

  typedef struct packed {
    logic        bEn;
    logic [2:0]  bSel;
    logic        iEn;
    logic [2:0]  iSel;
    logic [1:0]  scl;
    logic [1:0]  dsz;
    logic [31:0] disp;
    logic [31:0] expAddr;
  } vecT;

  localparam int VEC_N = 16;

  // register file contents seen through the read port
  localparam logic [31:0] RF [8] = '{
    32'h0000_1000, 32'hFFFF_FFF0, 32'h0000_0010, 32'h8000_0000,
    32'h1234_5678, 32'h0000_0003, 32'h7FFF_FFFF, 32'hFFFF_FFFF
  };

  localparam vecT VEC [VEC_N] = '{
    '{1'b0, 3'd0, 1'b0, 3'd0, 2'd0, 2'd3, 32'h0000_8000, 32'h0000_8000}, // R11 absolute
    '{1'b1, 3'd4, 1'b0, 3'd0, 2'd0, 2'd0, 32'h5555_5555, 32'h1234_5678}, // R11 base only
    '{1'b1, 3'd0, 1'b1, 3'd2, 2'd0, 2'd0, 32'h0,         32'h0000_1010}, // R6 x1
    '{1'b1, 3'd0, 1'b1, 3'd2, 2'd1, 2'd0, 32'h0,         32'h0000_1020}, // R6 x2
    '{1'b1, 3'd0, 1'b1, 3'd2, 2'd2, 2'd0, 32'h0,         32'h0000_1040}, // R6 x4
    '{1'b1, 3'd0, 1'b1, 3'd2, 2'd3, 2'd0, 32'h0,         32'h0000_1040}, // R6 code3
    '{1'b0, 3'd3, 1'b1, 3'd5, 2'd2, 2'd1, 32'h0000_0080, 32'hFFFF_FF8C}, // R8 R10
    '{1'b1, 3'd0, 1'b0, 3'd0, 2'd0, 2'd1, 32'hABCD_EF7F, 32'h0000_107F}, // R9 byte
    '{1'b1, 3'd0, 1'b0, 3'd0, 2'd0, 2'd2, 32'h1234_8000, 32'hFFFF_9000}, // R8 R9 half
    '{1'b1, 3'd7, 1'b0, 3'd0, 2'd0, 2'd3, 32'h0000_0001, 32'h0000_0000}, // R10 wrap
    '{1'b1, 3'd3, 1'b1, 3'd3, 2'd1, 2'd3, 32'h0000_0010, 32'h8000_0010}, // R10 shift wrap
    '{1'b1, 3'd6, 1'b1, 3'd1, 2'd0, 2'd2, 32'h0000_7FFF, 32'h8000_7FEE}, // R8 three terms
    '{1'b0, 3'd4, 1'b0, 3'd4, 2'd2, 2'd0, 32'hDEAD_BEEF, 32'h0000_0000}, // R5 R7 R8 none
    '{1'b0, 3'd7, 1'b1, 3'd2, 2'd1, 2'd1, 32'h0000_0001, 32'h0000_0021}, // R5 sel ignored
    '{1'b1, 3'd1, 1'b0, 3'd4, 2'd2, 2'd2, 32'hFFFF_0010, 32'h0000_0000}, // R7 R10
    '{1'b1, 3'd4, 1'b1, 3'd4, 2'd2, 2'd3, 32'hFFFF_FFFF, 32'h5B05_B057}  // R6 R8 full
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        baseEn = 1'b0;
  logic [2:0]  baseSel = '0;
  logic        indexEn = 1'b0;
  logic [2:0]  indexSel = '0;
  logic [1:0]  scaleCode = '0;
  logic [1:0]  dispSize = '0;
  logic [31:0] dispRaw = '0;
  logic [2:0]  rdIdxBase, rdIdxIndex;
  logic [31:0] rdDataBase, rdDataIndex;
  logic        outValid;
  logic [31:0] outAddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  assign rdDataBase  = RF[rdIdxBase];
  assign rdDataIndex = RF[rdIdxIndex];

  scaled_addr_gen u_scaled_addr_gen (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .baseEn     (baseEn),
    .baseSel    (baseSel),
    .indexEn    (indexEn),
    .indexSel   (indexSel),
    .scaleCode  (scaleCode),
    .dispSize   (dispSize),
    .dispRaw    (dispRaw),
    .rdIdxBase  (rdIdxBase),
    .rdIdxIndex (rdIdxIndex),
    .rdDataBase (rdDataBase),
    .rdDataIndex(rdDataIndex),
    .outValid   (outValid),
    .outAddr    (outAddr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input vecT v, input logic vld);
    inValid   = vld;
    baseEn    = v.bEn;
    baseSel   = v.bSel;
    indexEn   = v.iEn;
    indexSel  = v.iSel;
    scaleCode = v.scl;
    dispSize  = v.dsz;
    dispRaw   = v.disp;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 valid", 32'(outValid), 32'd0);
    check("R1 addr", outAddr, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R4 combinational read indices
    baseSel = 3'd5;
    indexSel = 3'd2;
    #1;
    check("R4 base idx", 32'(rdIdxBase), 32'd5);
    check("R4 index idx", 32'(rdIdxIndex), 32'd2);

    // table walked back to back (R2 and function requirements)
    for (int i = 0; i <= VEC_N; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check("R2 valid", 32'(outValid), 32'd1);
        check($sformatf("vector %0d addr", i - 1), outAddr, VEC[i-1].expAddr);
      end
      if (i < VEC_N) drive(VEC[i], 1'b1);
      else drive(VEC[0], 1'b0);
    end

    // R2 valid drops, R3 address holds under idle with changing fields
    @(negedge clk);
    check("R2 drop", 32'(outValid), 32'd0);
    check("R3 hold", outAddr, VEC[VEC_N-1].expAddr);
    drive(VEC[9], 1'b0);
    @(negedge clk);
    check("R3 hold idle", outAddr, VEC[VEC_N-1].expAddr);

    // R9 upper displacement bits differ, same result
    drive('{1'b1, 3'd0, 1'b0, 3'd0, 2'd0, 2'd1, 32'h0000_007F, 32'h0}, 1'b1);
    @(negedge clk);
    check("R9 clean upper", outAddr, 32'h0000_107F);
    drive('{1'b0, 3'd0, 1'b0, 3'd0, 2'd0, 2'd0, 32'h0, 32'h0}, 1'b0);

    // R1 asynchronous reset mid-run
    @(negedge clk);
    #2 rstN = 1'b0;
    #1;
    check("R1 async valid", 32'(outValid), 32'd0);
    check("R1 async addr", outAddr, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    finish_run();
  end

endmodule